// File: doc/BRIEF.md
# Peripheral DMA Channel Pointer and Counter

This block keeps the running state of one transfer direction (receive or transmit) of a serial peripheral's DMA channel. It holds a 32-bit memory address, the location of the next transfer, and a 16-bit count of the transfers still to be done. Software programs and reads both through a small register port with select, write strobe, word address and 32-bit data.

The transfer sequencer pulses `xfer_done` each time a transfer completes. On each pulse the block moves the address forward by the transfer size and takes one off the count. For a UART-style channel the address step is always 1. For an SPI channel the step is 1, 2 or 4, read from that SPI's 2-bit slot in a packed size bus. When the count is zero the block blocks the peripheral's ready line, so no further transfer is requested. It also holds an end flag high toward the peripheral. Software may rewrite either register while transfers are in progress, and the channel continues from the new values.

Top module: `dma_chan_regs`

## Requirements
- R1: A synchronous active-low reset clears the address and the count to zero. After reset `end_flag` is 1 and `trig_out` is 0.
- R2: With `reg_sel` high, word address 0 reads the 32-bit address and word address 1 reads the count in bits 15:0, with bits 31:16 reading zero. Addresses 2 and 3 read zero, and writes to them change nothing. With `reg_sel` low, `reg_rdata` is zero and writes are ignored.
- R3: On an SPI channel (`IS_SPI`=1), each counted transfer advances the address by the step given by bits [2*SPI_IDX+1 : 2*SPI_IDX] of `spi_size_bus`. The codes are 00 → 1, 01 → 2, 10 → 4 and 11 → 1. The other slots have no effect.
- R4: On a UART channel (`IS_SPI`=0), each counted transfer advances the address by 1, whatever `spi_size_bus` holds.
- R5: A `xfer_done` pulse while the count is nonzero lowers the count by one in the next cycle.
- R6: `trig_out` equals `periph_rdy` while the count is nonzero and is 0 while the count is zero.
- R7: `end_flag` is 1 exactly while the count is zero. It rises in the cycle after the pulse that takes the count from 1 to 0.
- R8: A `xfer_done` pulse while the count is zero changes neither register.
- R9: A write to the address register takes effect in the next cycle and wins over a completion pulse in the same cycle. The count still decrements on that pulse.
- R10: A write to the count register takes effect in the next cycle and wins over a completion pulse in the same cycle. The address still advances on that pulse.
- R11: The address wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 address, 1 count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| spi_size_bus | input | 2*NUM_SPI | Packed per-SPI size codes |
| periph_rdy | input | 1 | Peripheral ready trigger |
| xfer_done | input | 1 | One-cycle transfer completion pulse |
| trig_out | output | 1 | Gated ready toward the sequencer |
| end_flag | output | 1 | End-of-block flag toward the peripheral |

## Verification
The bench drives an SPI instance and a UART instance in parallel from the same stimulus. Completion pulses are given under each size code, and also with only a neighbouring slot set. This separates the selection of the size field from the decoding of the step, and the fixed UART step from the SPI step. Writes that coincide with pulses show which register takes priority. Pulses at a zero count, wrap of the address at the top of the range, and unmapped or unselected accesses cover the edges of the block.

// File: rtl/dma_chan_pkg.sv
// Shared types and register offsets for the DMA channel register pair.
// Assumes word addressing on the register port.
package dma_chan_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    localparam int REG_PTR = 0;
    localparam int REG_CNT = 1;
    localparam int STEP_W  = 3;
endpackage

// File: rtl/dma_step_sel.sv
// Picks the address step for one channel. The UART variant always steps 1.
// The SPI variant decodes its own 2-bit slot of the packed size bus.
// Assumes SPI_IDX < NUM_SPI.
module dma_step_sel
    import dma_chan_pkg::*;
#(
    parameter int NUM_SPI = 2,
    parameter bit IS_SPI  = 1'b1,
    parameter int SPI_IDX = 1
) (
    input  logic [2*NUM_SPI-1:0] size_bus,
    output logic [STEP_W-1:0]    step
);
    generate
        if (IS_SPI) begin : g_spi
            xfer_size_e code;
            // Select this channel's slot from the packed bus.
            assign code = xfer_size_e'(size_bus[2*SPI_IDX +: 2]);
            // Convert the size code into a byte step.
            always_comb begin
                unique case (code)
                    SZ_HALF: step = STEP_W'(2);
                    SZ_WORD: step = STEP_W'(4);
                    default: step = STEP_W'(1);
                endcase
            end
        end else begin : g_uart
            logic unused_bits;
            // The UART step is fixed, so the size bus is not used.
            assign unused_bits = ^size_bus;
            assign step = STEP_W'(1);
        end
    endgenerate
endmodule

// File: rtl/dma_ptr_reg.sv
// Memory address register. A load wins over an advance in the same cycle.
// Assumes advance is already qualified by a nonzero count.
module dma_ptr_reg
    import dma_chan_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PTR_W-1:0]  load_val,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    output logic [PTR_W-1:0]  ptr
);
    // Hold, load or advance the address each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (adv)  ptr <= ptr + PTR_W'(step);
    end
endmodule

// File: rtl/dma_cnt_reg.sv
// Remaining-transfer counter. A load wins over a decrement in the same cycle.
// Does not decrement past zero.
module dma_cnt_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_zero
);
    // Hold, load or decrement the count each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Flag the exhausted count for the gating logic.
    assign is_zero = (cnt == '0);

    p_dec_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !is_zero) |=> (cnt == $past(cnt) - 1'b1));

    p_zero_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && is_zero) |=> is_zero);
endmodule

// File: rtl/dma_chan_regs.sv
// One direction of a peripheral DMA channel: address and count registers,
// register access, address step selection and trigger gating.
// Assumes xfer_done is a one-cycle pulse from the sequencer.
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int PTR_W   = 32,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 2,
    parameter int NUM_SPI = 2,
    parameter bit IS_SPI  = 1'b1,
    parameter int SPI_IDX = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_sel,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [2*NUM_SPI-1:0] spi_size_bus,
    input  logic                 periph_rdy,
    input  logic                 xfer_done,
    output logic                 trig_out,
    output logic                 end_flag
);
    localparam logic [ADDR_W-1:0] A_PTR = ADDR_W'(REG_PTR);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(REG_CNT);

    logic              wr_ptr, wr_cnt, cnt_zero, advance;
    logic [STEP_W-1:0] step;
    logic [PTR_W-1:0]  ptr;
    logic [CNT_W-1:0]  cnt;

    // Decode software writes to each register.
    assign wr_ptr  = reg_sel && reg_wr && (reg_addr == A_PTR);
    assign wr_cnt  = reg_sel && reg_wr && (reg_addr == A_CNT);
    // A completion counts only while transfers remain.
    assign advance = xfer_done && !cnt_zero;

    dma_step_sel #(.NUM_SPI(NUM_SPI), .IS_SPI(IS_SPI), .SPI_IDX(SPI_IDX)) u_step (
        .size_bus (spi_size_bus),
        .step     (step)
    );

    dma_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_ptr),
        .load_val (reg_wdata[PTR_W-1:0]),
        .adv      (advance),
        .step     (step),
        .ptr      (ptr)
    );

    dma_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .dec      (xfer_done),
        .cnt      (cnt),
        .is_zero  (cnt_zero)
    );

    // Gate the peripheral trigger and raise the end flag once the count runs out.
    assign trig_out = periph_rdy && !cnt_zero;
    assign end_flag = cnt_zero;

    // Return the selected register, zero-extended, or zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            if (reg_addr == A_PTR)      reg_rdata[PTR_W-1:0] = ptr;
            else if (reg_addr == A_CNT) reg_rdata[CNT_W-1:0] = cnt;
        end
    end

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_ptr && cnt != '0) |=> (ptr == $past(ptr) + PTR_W'($past(step))));

    p_trig_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !trig_out);

    p_end_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_cnt && cnt == CNT_W'(1)) |=> end_flag);

    p_ptr_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr |=> (ptr == $past(reg_wdata[PTR_W-1:0])));

    p_cnt_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(reg_wdata[CNT_W-1:0])));

    p_zero_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_ptr && cnt == '0) |=> $stable(ptr));
endmodule

// File: tb/dma_chan_regs_tb.sv
// Drives an SPI channel (slot 1) and a UART channel from shared stimulus.
// Compares both against behavioural models on every clock.
module dma_chan_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, done = 1'b0, rdy = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  size = '0;
    logic [31:0] rd_s, rd_u;
    logic        trig_s, trig_u, end_s, end_u;

    int checks = 0, fails = 0;
    bit armed = 0;
    longint m_ptr[2];
    int     m_cnt[2];

    always #2 clk = ~clk;

    dma_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_s), .spi_size_bus(size),
        .periph_rdy(rdy), .xfer_done(done), .trig_out(trig_s), .end_flag(end_s));

    dma_chan_regs #(.IS_SPI(1'b0)) u_dut_usart (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rd_u), .spi_size_bus(size),
        .periph_rdy(rdy), .xfer_done(done), .trig_out(trig_u), .end_flag(end_u));

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic longint spi_step(logic [3:0] s);
        case (s[3:2])
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    function automatic longint exp_rd(int k);
        if (!sel) return 0;
        if (addr == 2'd0) return m_ptr[k];
        if (addr == 2'd1) return m_cnt[k];
        return 0;
    endfunction

    // Apply one cycle of stimulus at the falling edge, compare, then advance the models.
    task automatic cyc(string tag, logic s, logic w, logic [1:0] a, logic [31:0] d,
                       logic dn, logic r, logic [3:0] sz);
        sel = s; wr = w; addr = a; wdata = d; done = dn; rdy = r; size = sz;
        #1;
        if (armed) begin
            check(tag, "spi rdata", rd_s, exp_rd(0));
            check(tag, "uart rdata", rd_u, exp_rd(1));
            check(tag, "spi trig", trig_s, (m_cnt[0] != 0) && r);
            check(tag, "uart trig", trig_u, (m_cnt[1] != 0) && r);
            check(tag, "spi end", end_s, m_cnt[0] == 0);
            check(tag, "uart end", end_u, m_cnt[1] == 0);
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            int old_cnt = m_cnt[k];
            if (!rst_n) begin
                m_ptr[k] = 0; m_cnt[k] = 0;
            end else begin
                if (s && w && a == 2'd0) m_ptr[k] = d;
                else if (dn && old_cnt != 0)
                    m_ptr[k] = (m_ptr[k] + ((k == 0) ? spi_step(sz) : 1)) & 64'hFFFF_FFFF;
                if (s && w && a == 2'd1) m_cnt[k] = d[15:0];
                else if (dn && old_cnt != 0) m_cnt[k] = old_cnt - 1;
            end
        end
        armed = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc("R1", 0, 0, 0, 0, 0, 1, 0);
        cyc("R1", 0, 0, 0, 0, 0, 1, 0);
        rst_n = 1'b1;
        cyc("R1", 1, 0, 0, 0, 0, 1, 0);
        cyc("R1", 1, 0, 1, 0, 1, 1, 0);
        // Program the registers and read them back.
        cyc("R2", 1, 1, 0, 32'h0000_1000, 0, 1, 0);
        cyc("R2", 1, 1, 1, 32'hABCD_000A, 0, 1, 0);
        cyc("R2", 1, 0, 1, 0, 0, 1, 0);
        cyc("R6", 1, 0, 0, 0, 0, 0, 0);
        // Step under every size code and with only the neighbouring slot set.
        cyc("R3", 1, 0, 0, 0, 1, 1, 4'b0000);
        cyc("R3", 1, 0, 0, 0, 1, 1, 4'b0100);
        cyc("R3", 1, 0, 0, 0, 1, 1, 4'b1000);
        cyc("R3", 1, 0, 0, 0, 1, 1, 4'b1100);
        cyc("R4", 1, 0, 0, 0, 1, 1, 4'b0011);
        cyc("R5", 1, 0, 1, 0, 0, 1, 4'b1000);
        // Writes that coincide with completion pulses.
        cyc("R9", 1, 1, 0, 32'h0000_2000, 1, 1, 4'b1000);
        cyc("R9", 1, 0, 1, 0, 0, 1, 0);
        cyc("R10", 1, 1, 1, 32'h0000_0003, 1, 1, 4'b1000);
        cyc("R10", 1, 0, 0, 0, 0, 1, 0);
        cyc("R10", 1, 0, 1, 0, 0, 1, 0);
        // Run the count to zero.
        for (int i = 0; i < 3; i++) cyc("R7", 1, 0, 1, 0, 1, 1, 4'b0100);
        cyc("R7", 1, 0, 0, 0, 0, 1, 0);
        // Pulses at zero count must leave both registers untouched.
        cyc("R8", 1, 0, 0, 0, 1, 1, 4'b1000);
        cyc("R8", 1, 0, 1, 0, 1, 1, 4'b1000);
        cyc("R8", 1, 0, 0, 0, 0, 1, 0);
        // Unmapped and unselected accesses.
        cyc("R2", 1, 1, 2, 32'hDEAD_BEEF, 0, 1, 0);
        cyc("R2", 1, 0, 2, 0, 0, 1, 0);
        cyc("R2", 1, 1, 3, 32'h1234_5678, 0, 1, 0);
        cyc("R2", 1, 0, 3, 0, 0, 1, 0);
        cyc("R2", 0, 1, 0, 32'h5555_5555, 0, 1, 0);
        cyc("R2", 0, 1, 1, 32'h0000_0007, 0, 1, 0);
        cyc("R2", 1, 0, 0, 0, 0, 1, 0);
        cyc("R2", 1, 0, 1, 0, 0, 1, 0);
        // Address wrap at the top of the range.
        cyc("R11", 1, 1, 0, 32'hFFFF_FFFE, 0, 1, 0);
        cyc("R11", 1, 1, 1, 32'h0000_0004, 0, 1, 0);
        cyc("R11", 1, 0, 0, 0, 1, 1, 4'b1000);
        cyc("R11", 1, 0, 0, 0, 1, 1, 4'b1000);
        cyc("R11", 1, 0, 0, 0, 1, 0, 4'b0100);
        cyc("R11", 1, 0, 1, 0, 0, 1, 0);
        // Reset in the middle of a block.
        rst_n = 1'b0;
        cyc("R1", 1, 0, 0, 0, 1, 1, 0);
        rst_n = 1'b1;
        cyc("R1", 1, 0, 0, 0, 0, 1, 0);
        cyc("R1", 1, 0, 1, 0, 0, 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule